// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block holds the configuration registers of a multi-function peripheral controller and exposes them to a host through two adjacent byte-wide I/O ports. Out of reset the register space is locked: any index or data traffic is dropped. The host unlocks it by writing a key byte to the lower port. Once unlocked, the lower port takes a register index and the upper port reads or writes the selected register. A second key byte locks the space again. Register contents survive locking.

A logical-device selector picks one of several banked register sets. Each bank holds an enable bit, a primary and a secondary 16-bit I/O base, a primary and a secondary interrupt select, and two decoder control bytes. The block drives every bank's enable, bases, interrupt selects and decoder bytes on flat output buses. Address decoding downstream and the peripherals themselves live elsewhere.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the block is locked. The index and the device selector are 0x00. Every bank register is zero, so all enables, bases, interrupt selects and decoder bytes are zero.
- R2: While locked, writes to either port are ignored, except for the unlock key written to the index port. Reads of either port return 0xFF.
- R3: Writing 0x55 to the index port (BASE_ADDR, default 0x3F0) while locked unlocks the block. Writing 0x55 while unlocked changes nothing, including the index.
- R4: Writing 0xAA to the index port while unlocked locks the block. All register contents and outputs are kept.
- R5: While unlocked, a write to the index port (any value other than 0x55/0xAA) selects a register. Data port (BASE_ADDR+1) accesses then reach that register. An index port read returns the current index.
- R6: Index 0x20 reads the fixed identifier 0x30 and index 0x21 reads the fixed revision 0x01. Writes to both are ignored.
- R7: Index 0x07 holds the device selector, which is readable and writable. Banks exist for selector values 1, 2, 3, 4, 5, 7 and 8. For any other value, banked indices read 0x00 and writes to them are ignored.
- R8: Index 0x30 is the enable register of the selected bank. Bit 0 drives dev_en_o[selector], and reads return bit 0 only, with the upper bits zero.
- R9: Indices 0x60 (high byte) and 0x61 (low byte) form the primary base. Indices 0x62 and 0x63 form the secondary base. They drive the 16-bit slice [sel*16 +: 16] of pri_base_o and sec_base_o.
- R10: Index 0x70 is the primary interrupt select and 0x72 the secondary. Indices 0xF0 and 0xF1 are decoder control bytes. They drive the byte slice [sel*8 +: 8] of the matching output.
- R11: Any other index reads 0x00, and writes to it change no register and no output.
- R12: Accesses to addresses other than the two ports are ignored, and read data is 0x00 whenever no port read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | I/O write strobe, one cycle per access |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid while io_rd_i is high |
| dev_en_o | output | 9 | Per-bank enable |
| pri_base_o | output | 144 | Primary base per bank, 16 bits each |
| sec_base_o | output | 144 | Secondary base per bank |
| pri_irq_o | output | 72 | Primary interrupt select per bank |
| sec_irq_o | output | 72 | Secondary interrupt select per bank |
| dec0_o | output | 72 | Decoder control byte 0 per bank |
| dec1_o | output | 72 | Decoder control byte 1 per bank |

## Verification
The hardest cases to reach are those where the key bytes and the register index share the index port. An unlock key written while already unlocked must not overwrite a selected index. A write to a selector value that has no bank must leave every bank untouched. The stimulus first selects index 0x20 and then repeats the unlock key, reading the index port back to see that 0x20 survived. It then points the selector at 6 and writes the enable register, checking that dev_en_o stays exactly at its earlier value. After locking, the bench writes traffic to the data port and confirms that the outputs still hold what was programmed before the lock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IX_LDN    = 8'h07;
  localparam logic [7:0] IX_ID     = 8'h20;
  localparam logic [7:0] IX_REV    = 8'h21;
  localparam logic [7:0] IX_ACT    = 8'h30;
  localparam logic [7:0] IX_PB_HI  = 8'h60;
  localparam logic [7:0] IX_PB_LO  = 8'h61;
  localparam logic [7:0] IX_SB_HI  = 8'h62;
  localparam logic [7:0] IX_SB_LO  = 8'h63;
  localparam logic [7:0] IX_PIRQ   = 8'h70;
  localparam logic [7:0] IX_SIRQ   = 8'h72;
  localparam logic [7:0] IX_DEC0   = 8'hF0;
  localparam logic [7:0] IX_DEC1   = 8'hF1;

  typedef struct packed {
    logic        act;
    logic [15:0] pbase;
    logic [15:0] sbase;
    logic [7:0]  pirq;
    logic [7:0]  sirq;
    logic [7:0]  dec0;
    logic [7:0]  dec1;
  } bank_t;

  function automatic logic is_bank_ix(input logic [7:0] ix);
    case (ix)
      IX_ACT, IX_PB_HI, IX_PB_LO, IX_SB_HI, IX_SB_LO,
      IX_PIRQ, IX_SIRQ, IX_DEC0, IX_DEC1: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] bank_rd(input bank_t b, input logic [7:0] ix);
    case (ix)
      IX_ACT:   return {7'd0, b.act};
      IX_PB_HI: return b.pbase[15:8];
      IX_PB_LO: return b.pbase[7:0];
      IX_SB_HI: return b.sbase[15:8];
      IX_SB_LO: return b.sbase[7:0];
      IX_PIRQ:  return b.pirq;
      IX_SIRQ:  return b.sirq;
      IX_DEC0:  return b.dec0;
      IX_DEC1:  return b.dec1;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       cfg_o
);
  typedef enum logic {ST_RUN, ST_CFG} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      if (st_q == ST_RUN && wdata_i == KEY_OPEN)  st_d = ST_CFG;
      if (st_q == ST_CFG && wdata_i == KEY_CLOSE) st_d = ST_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;

  assign cfg_o = (st_q == ST_CFG);

  AST_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr_i && wdata_i == KEY_OPEN) |=> cfg_o); // R3
  AST_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr_i && cfg_o && wdata_i == KEY_CLOSE) |=> !cfg_o); // R4
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output bank_t      regs_o
);
  bank_t r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_q <= '0;
    else if (wr_i) begin
      case (idx_i)
        IX_ACT:   r_q.act         <= wdata_i[0];
        IX_PB_HI: r_q.pbase[15:8] <= wdata_i;
        IX_PB_LO: r_q.pbase[7:0]  <= wdata_i;
        IX_SB_HI: r_q.sbase[15:8] <= wdata_i;
        IX_SB_LO: r_q.sbase[7:0]  <= wdata_i;
        IX_PIRQ:  r_q.pirq        <= wdata_i;
        IX_SIRQ:  r_q.sirq        <= wdata_i;
        IX_DEC0:  r_q.dec0        <= wdata_i;
        IX_DEC1:  r_q.dec1        <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign regs_o = r_q;

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_o)); // R7
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     BASE_ADDR = 16'h03F0,
  parameter int              NUM_LDN   = 9,
  parameter logic [8:0]      DEV_MASK  = 9'h1BE,
  parameter logic [7:0]      CHIP_ID   = 8'h30,
  parameter logic [7:0]      CHIP_REV  = 8'h01
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  io_wr_i,
  input  logic                  io_rd_i,
  input  logic [ADDR_W-1:0]     io_addr_i,
  input  logic [7:0]            io_wdata_i,
  output logic [7:0]            io_rdata_o,
  output logic [NUM_LDN-1:0]    dev_en_o,
  output logic [NUM_LDN*16-1:0] pri_base_o,
  output logic [NUM_LDN*16-1:0] sec_base_o,
  output logic [NUM_LDN*8-1:0]  pri_irq_o,
  output logic [NUM_LDN*8-1:0]  sec_irq_o,
  output logic [NUM_LDN*8-1:0]  dec0_o,
  output logic [NUM_LDN*8-1:0]  dec1_o
);
  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_ADDR + 16'd1);

  logic       cfg;
  logic       hit_idx, hit_dat;
  logic [7:0] idx_q, ldn_q;
  logic       bank_wr;
  bank_t      regs [NUM_LDN];
  bank_t      sel_regs;
  logic [7:0] reg_rd;

  assign hit_idx = (io_addr_i == IDX_PORT);
  assign hit_dat = (io_addr_i == DAT_PORT);

  cfg_key_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (io_wr_i && hit_idx),
    .wdata_i  (io_wdata_i),
    .cfg_o    (cfg)
  );

  // keys never land in the index register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else if (cfg && io_wr_i) begin
      if (hit_idx && io_wdata_i != KEY_OPEN && io_wdata_i != KEY_CLOSE)
        idx_q <= io_wdata_i;
      if (hit_dat && idx_q == IX_LDN)
        ldn_q <= io_wdata_i;
    end
  end

  assign bank_wr = cfg && io_wr_i && hit_dat && is_bank_ix(idx_q);

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
    if (DEV_MASK[g]) begin : g_real
      cfg_bank u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bank_wr && ldn_q == 8'(g)),
        .idx_i   (idx_q),
        .wdata_i (io_wdata_i),
        .regs_o  (regs[g])
      );
    end else begin : g_none
      assign regs[g] = '0;
    end
    assign dev_en_o[g]            = regs[g].act;
    assign pri_base_o[g*16 +: 16] = regs[g].pbase;
    assign sec_base_o[g*16 +: 16] = regs[g].sbase;
    assign pri_irq_o[g*8 +: 8]    = regs[g].pirq;
    assign sec_irq_o[g*8 +: 8]    = regs[g].sirq;
    assign dec0_o[g*8 +: 8]       = regs[g].dec0;
    assign dec1_o[g*8 +: 8]       = regs[g].dec1;
  end

  always_comb begin
    sel_regs = '0;
    for (int i = 0; i < NUM_LDN; i++)
      if (ldn_q == 8'(i)) sel_regs = regs[i];
  end

  always_comb begin
    case (idx_q)
      IX_LDN:  reg_rd = ldn_q;
      IX_ID:   reg_rd = CHIP_ID;
      IX_REV:  reg_rd = CHIP_REV;
      default: reg_rd = bank_rd(sel_regs, idx_q);
    endcase
  end

  always_comb begin
    io_rdata_o = 8'h00;
    if (io_rd_i) begin
      if (hit_idx)      io_rdata_o = cfg ? idx_q  : 8'hFF;
      else if (hit_dat) io_rdata_o = cfg ? reg_rd : 8'hFF;
    end
  end

  AST_RUN_READ_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && hit_dat && !cfg) |-> io_rdata_o == 8'hFF); // R2
  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && hit_dat && cfg && idx_q == IX_ID) |-> io_rdata_o == CHIP_ID); // R6
  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == 8'h00); // R12
  AST_RUN_NO_OUT_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg && !$past(cfg)) |-> $stable(dev_en_o)); // R2
endmodule

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IP = 16'h03F0;
  localparam logic [15:0] DP = 16'h03F1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [15:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [8:0]   dev_en;
  logic [143:0] pbase, sbase;
  logic [71:0]  pirq, sirq, dec0, dec1;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(wr), .io_rd_i(rd),
    .io_addr_i(addr), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .dev_en_o(dev_en), .pri_base_o(pbase), .sec_base_o(sbase),
    .pri_irq_o(pirq), .sec_irq_o(sirq), .dec0_o(dec0), .dec1_o(dec1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = '0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #(CLK_PERIOD/4); d = rdata;
    @(negedge clk); rd = 1'b0; addr = '0;
  endtask

  task automatic rd_reg(input logic [7:0] ix, output logic [7:0] d);
    io_wr(IP, ix); io_rd(DP, d);
  endtask

  task automatic wr_reg(input logic [7:0] ix, input logic [7:0] v);
    io_wr(IP, ix); io_wr(DP, v);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    #1;
    chk("R1 dev_en", 32'(dev_en), 0);
    chk("R1 pbase", 32'(|pbase | |sbase | |pirq | |sirq | |dec0 | |dec1), 0);
    chk("R12 idle rdata", 32'(rdata), 0);
    io_rd(DP, d); chk("R2 run data read", 32'(d), 32'hFF);
    io_rd(IP, d); chk("R2 run index read", 32'(d), 32'hFF);
  endtask

  task automatic t_run_ignore;
    logic [7:0] d;
    io_wr(IP, 8'h07); io_wr(DP, 8'h04);
    io_wr(IP, 8'h30); io_wr(DP, 8'h01);
    chk("R2 run write no enable", 32'(dev_en), 0);
    io_wr(IP, 8'h55);
    io_rd(IP, d); chk("R1 R2 index after unlock", 32'(d), 0);
    rd_reg(8'h07, d); chk("R2 selector untouched", 32'(d), 0);
  endtask

  task automatic t_unlock_repeat;
    logic [7:0] d;
    io_wr(IP, 8'h20);
    io_rd(IP, d); chk("R5 index readback", 32'(d), 32'h20);
    io_wr(IP, 8'h55);
    io_rd(IP, d); chk("R3 repeat key keeps index", 32'(d), 32'h20);
    io_rd(DP, d); chk("R3 still unlocked", 32'(d), 32'h30);
  endtask

  task automatic t_id;
    logic [7:0] d;
    rd_reg(8'h20, d); chk("R6 id", 32'(d), 32'h30);
    rd_reg(8'h21, d); chk("R6 rev", 32'(d), 32'h01);
    wr_reg(8'h20, 8'h99); io_rd(DP, d); chk("R6 id read-only", 32'(d), 32'h30);
  endtask

  task automatic t_banks;
    logic [7:0] d;
    wr_reg(8'h07, 8'h04);
    wr_reg(8'h30, 8'hFF);
    wr_reg(8'h60, 8'h03); wr_reg(8'h61, 8'hF8);
    wr_reg(8'h70, 8'h04);
    chk("R8 enable ldn4", 32'(dev_en), 32'h010);
    chk("R9 pbase ldn4", 32'(pbase[4*16 +: 16]), 32'h03F8);
    chk("R10 pirq ldn4", 32'(pirq[4*8 +: 8]), 32'h04);
    rd_reg(8'h30, d); chk("R8 act readback bit0", 32'(d), 32'h01);
    wr_reg(8'h07, 8'h01);
    wr_reg(8'h30, 8'h01);
    wr_reg(8'h60, 8'h01); wr_reg(8'h61, 8'hF0);
    wr_reg(8'h62, 8'h03); wr_reg(8'h63, 8'hF6);
    wr_reg(8'h70, 8'h0E); wr_reg(8'h72, 8'h0F);
    wr_reg(8'hF0, 8'h0C); wr_reg(8'hF1, 8'h5A);
    chk("R8 enable ldn1+4", 32'(dev_en), 32'h012);
    chk("R9 pbase ldn1", 32'(pbase[1*16 +: 16]), 32'h01F0);
    chk("R9 sbase ldn1", 32'(sbase[1*16 +: 16]), 32'h03F6);
    chk("R10 sirq ldn1", 32'(sirq[1*8 +: 8]), 32'h0F);
    chk("R10 dec0 ldn1", 32'(dec0[1*8 +: 8]), 32'h0C);
    chk("R10 dec1 ldn1", 32'(dec1[1*8 +: 8]), 32'h5A);
    chk("R9 ldn4 kept", 32'(pbase[4*16 +: 16]), 32'h03F8);
    wr_reg(8'h07, 8'h04);
    rd_reg(8'h61, d); chk("R7 bank switch read", 32'(d), 32'hF8);
    rd_reg(8'h07, d); chk("R7 selector read", 32'(d), 32'h04);
  endtask

  task automatic t_undef;
    logic [7:0] d;
    wr_reg(8'h07, 8'h06);
    wr_reg(8'h30, 8'h01);
    wr_reg(8'h60, 8'h12);
    chk("R7 undefined bank no enable", 32'(dev_en), 32'h012);
    chk("R7 undefined bank no base", 32'(pbase[6*16 +: 16]), 0);
    rd_reg(8'h30, d); chk("R7 undefined bank reads 0", 32'(d), 0);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    wr_reg(8'h07, 8'h01);
    wr_reg(8'h71, 8'hA5);
    io_rd(DP, d); chk("R11 unimplemented reads 0", 32'(d), 0);
    chk("R11 neighbours intact", 32'({pirq[15:8], sirq[15:8]}), 32'h0E0F);
    io_wr(16'h03F2, 8'h77);
    io_rd(16'h03F2, d); chk("R12 foreign read", 32'(d), 0);
    io_rd(IP, d); chk("R12 foreign write ignored", 32'(d), 32'h71);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    io_wr(IP, 8'hAA);
    io_rd(DP, d); chk("R4 locked data read", 32'(d), 32'hFF);
    io_wr(IP, 8'h30); io_wr(DP, 8'h00);
    chk("R4 outputs kept", 32'(dev_en), 32'h012);
    chk("R4 base kept", 32'(pbase[1*16 +: 16]), 32'h01F0);
    io_wr(16'h02F0, 8'h55);
    io_rd(DP, d); chk("R12 foreign key ignored", 32'(d), 32'hFF);
    io_wr(IP, 8'h55);
    rd_reg(8'h60, d); chk("R4 content survives lock", 32'(d), 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_run_ignore;
    t_unlock_repeat;
    t_id;
    t_banks;
    t_undef;
    t_unimpl;
    t_lock;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule